// File: doc/BRIEF.md
# Shared-Counter PWM Channel with Shutdown

This block makes one output channel of a motor-drive PWM for a half-bridge leg. It owns no counter. A free-running period counter, shared by several channels, is fed to it each clock together with a one-cycle wrap pulse that is high while the counter shows zero. The channel compares the counter with a buffered duty threshold and produces a registered positive drive output and a separate shutdown output. The shutdown output disables the bridge leg while it is high.

The threshold and the two enable bits arrive on plain inputs. They are copied into a shadow set only on a clock edge where both the wrap pulse and a data-valid qualifier are high. A new period therefore always starts with a coherent set of settings, and a half-written update never reaches the power stage. A failsafe input bypasses the registers and turns the leg off in the same cycle. After reset the channel stays off until the first accepted update.

Top module: `pwm_shared_cnt_ch`

## Requirements
- R1: While reset is asserted, and afterwards until the first accepted update, `drive_o` is 0 and `shdn_o` is 1.
- R2: The settings `match_i`, `en_pos_i` and `en_shdn_i` are accepted only on a rising clock edge where `sync_i` and `data_valid_i` are both 1.
- R3: If `data_valid_i` is 0 at a wrap edge, the previous settings stay in force. Changes to the inputs on edges where `sync_i` is 0 have no effect.
- R4: When the active drive enable is 1, `drive_o` is 1 in the cycle after the edge that sampled counter value c if c < active match, and 0 otherwise.
- R5: A match of 0 gives a drive that is never high. A match of all-ones gives a drive that is high for every counter value except all-ones.
- R6: When the active `en_pos` is 0, `drive_o` stays 0.
- R7: When the active `en_shdn` is 0, `shdn_o` is 1. When it is 1, `shdn_o` is 0.
- R8: While `failsafe_i` is 1, `drive_o` is 0 and `shdn_o` is 1 in the same cycle, whatever the other state.
- R9: Settings accepted at a wrap edge already govern the output produced from the counter value 0 sampled at that same edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_i | input | 1 | Wrap pulse, high while the shared counter shows zero |
| data_valid_i | input | 1 | Settings inputs are consistent |
| failsafe_i | input | 1 | Forces the leg off |
| en_pos_i | input | 1 | Enable for the positive drive |
| en_shdn_i | input | 1 | Enable for the leg; 0 asserts shutdown |
| match_i | input | MATCH_W | Duty threshold |
| count_i | input | MATCH_W | Shared counter value |
| drive_o | output | 1 | Positive drive output |
| shdn_o | output | 1 | Shutdown output, 1 = leg disabled |

## Verification
The bench builds the channel with `MATCH_W` = 5, so one counter period lasts 32 cycles. This lets the random phase cover about a hundred wraps: many accepted and rejected updates, and both duty extremes (match 0 and match 31). The saturated threshold and the all-ones counter value meet often enough to check the last-tick low of R5. The default width changes only the period length, so the same update and compare rules are reached at a size that runs quickly.

// File: rtl/pwm_ch_pkg.sv
package pwm_ch_pkg;
  typedef struct packed {
    logic en_pos;
    logic en_shdn;
  } pwm_flags_t;

  localparam pwm_flags_t FLAGS_OFF = '{en_pos: 1'b0, en_shdn: 1'b0};
endpackage

// File: rtl/pwm_shadow_reg.sv
module pwm_shadow_reg
  import pwm_ch_pkg::*;
#(
  parameter int MATCH_W = 11
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_i,
  input  logic [MATCH_W-1:0] match_i,
  input  pwm_flags_t         flags_i,
  output logic [MATCH_W-1:0] match_o,
  output pwm_flags_t         flags_o,
  output logic [MATCH_W-1:0] eff_match_o,
  output pwm_flags_t         eff_flags_o
);
  logic [MATCH_W-1:0] match_q, match_d;
  pwm_flags_t         flags_q, flags_d;

  always_comb begin
    match_d = match_q;
    flags_d = flags_q;
    if (load_i) begin
      match_d = match_i;
      flags_d = flags_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      match_q <= '0;
      flags_q <= FLAGS_OFF;
    end else begin
      match_q <= match_d;
      flags_q <= flags_d;
    end
  end

  assign match_o     = match_q;
  assign flags_o     = flags_q;
  assign eff_match_o = match_d;
  assign eff_flags_o = flags_d;

  // R3: without a load the shadow settings hold
  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> ($stable(match_q) && $stable(flags_q)));
  // R2: a load takes the inputs
  assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (match_q == $past(match_i)));
endmodule

// File: rtl/pwm_compare.sv
module pwm_compare
  import pwm_ch_pkg::*;
#(
  parameter int MATCH_W = 11
) (
  input  logic [MATCH_W-1:0] count_i,
  input  logic [MATCH_W-1:0] match_i,
  input  pwm_flags_t         flags_i,
  output logic               drive_nxt_o,
  output logic               shdn_nxt_o
);
  logic below;

  always_comb begin
    below       = (count_i < match_i);
    drive_nxt_o = flags_i.en_pos & below;
    shdn_nxt_o  = ~flags_i.en_shdn;
  end
endmodule

// File: rtl/pwm_out_stage.sv
module pwm_out_stage (
  input  logic clk,
  input  logic rst_n,
  input  logic drive_nxt_i,
  input  logic shdn_nxt_i,
  input  logic failsafe_i,
  output logic drive_o,
  output logic shdn_o
);
  logic drive_q, shdn_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drive_q <= 1'b0;
      shdn_q  <= 1'b1;
    end else begin
      drive_q <= drive_nxt_i;
      shdn_q  <= shdn_nxt_i;
    end
  end

  always_comb begin
    drive_o = drive_q & ~failsafe_i;
    shdn_o  = shdn_q | failsafe_i;
  end

  // R8: failsafe turns the leg off
  assert_failsafe_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    failsafe_i |-> (!drive_o && shdn_o));
  // R4: the registered drive follows the compare result one edge later
  assert_drive_reg_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !drive_nxt_i |=> !drive_q);
endmodule

// File: rtl/pwm_shared_cnt_ch.sv
module pwm_shared_cnt_ch
  import pwm_ch_pkg::*;
#(
  parameter int MATCH_W = 11
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sync_i,
  input  logic               data_valid_i,
  input  logic               failsafe_i,
  input  logic               en_pos_i,
  input  logic               en_shdn_i,
  input  logic [MATCH_W-1:0] match_i,
  input  logic [MATCH_W-1:0] count_i,
  output logic               drive_o,
  output logic               shdn_o
);
  localparam logic [MATCH_W-1:0] CNT_TOP = {MATCH_W{1'b1}};

  logic               load;
  pwm_flags_t         in_flags, sh_flags, eff_flags;
  logic [MATCH_W-1:0] sh_match, eff_match;
  logic               drive_nxt, shdn_nxt;

  assign load     = sync_i & data_valid_i;
  assign in_flags = '{en_pos: en_pos_i, en_shdn: en_shdn_i};

  pwm_shadow_reg #(.MATCH_W(MATCH_W)) u_shadow (
    .clk(clk), .rst_n(rst_n), .load_i(load),
    .match_i(match_i), .flags_i(in_flags),
    .match_o(sh_match), .flags_o(sh_flags),
    .eff_match_o(eff_match), .eff_flags_o(eff_flags)
  );

  pwm_compare #(.MATCH_W(MATCH_W)) u_cmp (
    .count_i(count_i), .match_i(eff_match), .flags_i(eff_flags),
    .drive_nxt_o(drive_nxt), .shdn_nxt_o(shdn_nxt)
  );

  pwm_out_stage u_out (
    .clk(clk), .rst_n(rst_n),
    .drive_nxt_i(drive_nxt), .shdn_nxt_i(shdn_nxt),
    .failsafe_i(failsafe_i),
    .drive_o(drive_o), .shdn_o(shdn_o)
  );

  // R5: zero threshold never drives
  assert_duty_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && sh_match == '0) |=> !drive_o);
  // R5: at the top counter value the drive is low
  assert_top_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (count_i == CNT_TOP) |=> !drive_o);
  // R6: disabled positive side stays low
  assert_pos_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !sh_flags.en_pos) |=> !drive_o);
  // R7: disabled leg keeps shutdown asserted
  assert_shdn_on_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !sh_flags.en_shdn) |=> shdn_o);
  // R9: enables accepted at a wrap govern the next output
  assert_apply_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !en_shdn_i) |=> shdn_o);
endmodule

// File: tb/pwm_shared_cnt_ch_tb.sv
module pwm_shared_cnt_ch_tb_top;
  localparam int W   = 5;
  localparam int TOP = (1 << W) - 1;

  logic clk = 1'b0;
  logic rst_n;
  logic sync_i, data_valid_i, failsafe_i, en_pos_i, en_shdn_i;
  logic [W-1:0] match_i, count_i;
  logic drive_o, shdn_o;

  always #2.5 clk = ~clk;

  pwm_shared_cnt_ch #(.MATCH_W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .sync_i(sync_i), .data_valid_i(data_valid_i),
    .failsafe_i(failsafe_i), .en_pos_i(en_pos_i), .en_shdn_i(en_shdn_i),
    .match_i(match_i), .count_i(count_i), .drive_o(drive_o), .shdn_o(shdn_o)
  );

  int n_chk = 0, n_fail = 0, cyc = 0;
  int cnt = 0;
  int m_match = 0;
  bit m_pos = 0, m_shdn = 0;
  bit exp_dq = 0, exp_sq = 1;
  string req = "R1";
  bit done = 0;

  function automatic bit f_drive(bit q, bit fs);
    return q & !fs;
  endfunction
  function automatic bit f_shdn(bit q, bit fs);
    return q | fs;
  endfunction

  task automatic check(string r, logic act_d, logic act_s, bit ed, bit es);
    n_chk++;
    if (act_d !== ed || act_s !== es) begin
      n_fail++;
      $display("FAIL %s cycle %0d: drive=%b shdn=%b expected drive=%b shdn=%b",
               r, cyc, act_d, act_s, ed, es);
    end
  endtask

  // one counter tick: drive inputs, check outputs, advance model
  task automatic step(bit dv, bit fs, bit ep, bit en, int m);
    bit ld;
    count_i = cnt[W-1:0];
    sync_i = (cnt == 0);
    data_valid_i = dv; failsafe_i = fs;
    en_pos_i = ep; en_shdn_i = en; match_i = m[W-1:0];
    #1;
    check(req, drive_o, shdn_o, f_drive(exp_dq, fs), f_shdn(exp_sq, fs));
    ld = (cnt == 0) && dv;
    if (ld) begin m_match = m; m_pos = ep; m_shdn = en; end
    exp_dq = m_pos && (cnt < m_match);
    exp_sq = !m_shdn;
    @(posedge clk); @(negedge clk);
    cyc++;
    cnt = (cnt + 1) % (TOP + 1);
  endtask

  task automatic period(bit dv, bit ep, bit en, int m);
    for (int i = 0; i <= TOP; i++) step(dv, 1'b0, ep, en, m);
  endtask

  initial begin
    int unsigned seed;
    seed = 32'd1357;
    void'($urandom(seed));
    rst_n = 1'b0;
    sync_i = 0; data_valid_i = 0; failsafe_i = 0;
    en_pos_i = 1; en_shdn_i = 1; match_i = '0; count_i = '0;
    repeat (3) @(negedge clk);
    req = "R1";
    check("R1", drive_o, shdn_o, 1'b0, 1'b1);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: no accepted update yet
    period(1'b0, 1'b1, 1'b1, 20);
    // R2/R9: accepted update takes effect from count 0
    req = "R9"; step(1'b1, 1'b0, 1'b1, 1'b1, 12);
    req = "R4"; for (int i = 1; i <= TOP; i++) step(1'b0, 1'b0, 1'b1, 1'b1, 3);
    // R3: valid low at wrap keeps previous settings
    req = "R3"; period(1'b0, 1'b0, 1'b0, 30);
    // R2: valid high away from wrap has no effect
    req = "R2"; step(1'b0, 1'b0, 1'b1, 1'b1, 12);
    for (int i = 1; i <= TOP; i++) step(1'b1, 1'b0, 1'b0, 1'b0, 0);
    // R5: zero and full threshold
    req = "R5"; period(1'b1, 1'b1, 1'b1, 0);
    period(1'b1, 1'b1, 1'b1, TOP);
    period(1'b1, 1'b1, 1'b1, TOP);
    // R6: positive enable off
    req = "R6"; period(1'b1, 1'b0, 1'b1, 17);
    period(1'b1, 1'b0, 1'b1, 17);
    // R7: leg enable off then on
    req = "R7"; period(1'b1, 1'b1, 1'b0, 9);
    period(1'b1, 1'b1, 1'b1, 9);
    // R8: failsafe in mid-period with active drive
    req = "R8";
    step(1'b1, 1'b0, 1'b1, 1'b1, 25);
    for (int i = 1; i <= TOP; i++) step(1'b0, (i % 3) == 0, 1'b1, 1'b1, 25);
    // random mix
    req = "R4";
    for (int i = 0; i < 3000; i++) begin
      bit dv, fs, ep, en;
      int m;
      dv = ($urandom % 3) != 0;
      fs = ($urandom % 10) == 0;
      ep = ($urandom % 4) != 0;
      en = ($urandom % 4) != 0;
      case ($urandom % 4)
        0: m = 0;
        1: m = TOP;
        default: m = int'($urandom % (TOP + 1));
      endcase
      step(dv, fs, ep, en, m);
    end
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule